// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Index Qualification

This block turns the raw A, B and index lines of an incremental encoder into one-cycle count pulses, each with a direction bit, for a downstream position counter. Each line first passes through a synchronizer and then a sample-agreement filter. The decoder then tracks the filtered A/B pair. Illegal transitions, where both lines move in the same filtered sample, are reported as noise and produce no count.

A two-bit resolution selector picks one of four behaviours. Setting 0 is a clock-plus-direction mode that skips the filter: a rising edge of synchronized A is a count, and B gives the direction. Settings 1, 2 and 3 decode quadrature at one, two or four counts per encoder cycle. An index strobe is produced in one of two ways. It can follow the filtered index level directly, active low. It can also be qualified so that it fires only with a decoded count, when the index matches a programmable polarity. The qualified form is only available while quadrature decoding is selected. An input enable suppresses every count.

Top module: `qdec_top`

## Requirements
- R1: With res_mode = 0, each rising edge of synchronized enc_a gives exactly one cnt_en pulse, with cnt_up equal to enc_b (1 = up, 0 = down). The filter is bypassed, so a one-cycle high pulse on enc_a is counted.
- R2: res_mode encodes the resolution: 1 gives one count, 2 gives two counts and 3 gives four counts per full encoder cycle.
- R3: In quadrature modes, the filtered (A,B) sequence 00, 10, 11, 01 counts up (cnt_up = 1), and the reverse sequence counts down.
- R4: In quadrature modes, a change on an encoder line is accepted only after it has held for 3 consecutive clock samples. A 2-cycle glitch produces no count.
- R5: In quadrature modes, a filtered sample in which both A and B change produces no count and sets noise_err. noise_err then stays set until reset.
- R6: noise_err is held at 0 for as long as res_mode = 0.
- R7: While ab_en = 0, cnt_en stays 0 whatever the encoder lines do.
- R8: In the level-driven index mode, idx_strobe is high for one cycle per cycle that the filtered enc_idx is low. A low of L cycles gives L strobes.
- R9: In the qualified index mode (idx_sync = 1 and res_mode not 0), idx_strobe fires only in a cycle that also has cnt_en, and only when the filtered enc_idx equals idx_pol.
- R10: With res_mode = 0, idx_sync is ignored and the index behaves as in R8.
- R11: After reset, cnt_en, cnt_up, idx_strobe and noise_err are 0. An idle line with enc_idx high produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder A line (count clock in mode 0) |
| enc_b | input | 1 | Encoder B line (direction in mode 0) |
| enc_idx | input | 1 | Encoder index line |
| ab_en | input | 1 | Enables count generation |
| res_mode | input | 2 | 0 clock+direction, 1 x1, 2 x2, 3 x4 |
| idx_sync | input | 1 | Requests the count-qualified index mode |
| idx_pol | input | 1 | Active level of the index in qualified mode |
| cnt_en | output | 1 | One-cycle count pulse |
| cnt_up | output | 1 | Direction of the pulse, 1 = up |
| idx_strobe | output | 1 | Index strobe |
| noise_err | output | 1 | Sticky illegal-transition flag |

## Verification
The hardest states to reach from the ports are the filter boundary and the double-change noise case. The encoder lines are asynchronous to each other in practice, yet both must land in the same filtered sample. The bench drives A and B on the same clock edge. Because both paths have identical latency, they flip together after filtering. Pulses of exactly two and three cycles probe the agreement window from both sides. Full resolution and direction sweeps compare pulse totals against counts worked out per encoder cycle.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    typedef enum logic [1:0] {
        RES_NQ = 2'd0,
        RES_X1 = 2'd1,
        RES_X2 = 2'd2,
        RES_X4 = 2'd3
    } res_e;

    typedef struct packed {
        logic a;
        logic b;
    } ab_t;

    typedef struct packed {
        logic fire;
        logic up;
    } step_t;

    localparam int SYNC_DEPTH = 2;
    localparam int AGREE_LEN  = 3;

    // direction of a single-line move: new A differs from old B -> up
    function automatic logic move_up(ab_t prev, ab_t cur);
        return cur.a ^ prev.b;
    endfunction
endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_LEN    = 3,
    parameter logic RST_VAL     = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic raw_cur,
    output logic raw_prev,
    output logic filt
);
    logic [SYNC_STAGES-1:0] sy;
    logic [FILT_LEN-1:0]    hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            sy   <= {SYNC_STAGES{RST_VAL}};
            hist <= {FILT_LEN{RST_VAL}};
            filt <= RST_VAL;
        end else begin
            sy   <= {sy[SYNC_STAGES-2:0], din};
            hist <= {hist[FILT_LEN-2:0], sy[SYNC_STAGES-1]};
            if ((&hist) || !(|hist))
                filt <= hist[0];
        end
    end

    assign raw_cur  = hist[0];
    assign raw_prev = hist[1];
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
    import qdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  res_e  res,
    input  logic  ab_en,
    input  ab_t   filt,
    input  logic  raw_a_cur,
    input  logic  raw_a_prev,
    input  logic  raw_b_cur,
    output step_t step,
    output logic  noise_hit
);
    ab_t  prev;
    logic chg_a, chg_b, single, take;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= filt;
    end

    assign chg_a  = filt.a ^ prev.a;
    assign chg_b  = filt.b ^ prev.b;
    assign single = chg_a ^ chg_b;

    always_comb begin
        unique case (res)
            RES_X4:  take = single;
            RES_X2:  take = single && chg_a;
            RES_X1:  take = single && chg_a && !filt.b;
            default: take = 1'b0;
        endcase
    end

    always_comb begin
        if (res == RES_NQ) begin
            step.fire = ab_en && raw_a_cur && !raw_a_prev;
            step.up   = raw_b_cur;
        end else begin
            step.fire = ab_en && take;
            step.up   = move_up(prev, filt);
        end
    end

    assign noise_hit = (res != RES_NQ) && chg_a && chg_b;
endmodule

// File: rtl/qdec_index.sv
module qdec_index (
    input  logic idx_filt,
    input  logic sync_req,
    input  logic quad,
    input  logic pol,
    input  logic fire,
    output logic strobe
);
    logic sync_eff;
    assign sync_eff = sync_req && quad;
    assign strobe   = sync_eff ? (fire && (idx_filt == pol)) : !idx_filt;
endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH,
    parameter int FILT_LEN    = AGREE_LEN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic       enc_idx,
    input  logic       ab_en,
    input  logic [1:0] res_mode,
    input  logic       idx_sync,
    input  logic       idx_pol,
    output logic       cnt_en,
    output logic       cnt_up,
    output logic       idx_strobe,
    output logic       noise_err
);
    localparam int NLINES = 3;

    logic [NLINES-1:0] lines, raw_cur, raw_prev, filt;
    res_e  res;
    step_t step;
    logic  noise_hit, strobe;

    assign lines = {enc_idx, enc_b, enc_a};
    assign res   = res_e'(res_mode);

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        qdec_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN),
            .RST_VAL    ((g == NLINES - 1) ? 1'b1 : 1'b0)
        ) filt_i (
            .clk     (clk),
            .rst     (rst),
            .din     (lines[g]),
            .raw_cur (raw_cur[g]),
            .raw_prev(raw_prev[g]),
            .filt    (filt[g])
        );
    end

    qdec_decode dec_i (
        .clk       (clk),
        .rst       (rst),
        .res       (res),
        .ab_en     (ab_en),
        .filt      ('{a: filt[0], b: filt[1]}),
        .raw_a_cur (raw_cur[0]),
        .raw_a_prev(raw_prev[0]),
        .raw_b_cur (raw_cur[1]),
        .step      (step),
        .noise_hit (noise_hit)
    );

    qdec_index idx_i (
        .idx_filt(filt[2]),
        .sync_req(idx_sync),
        .quad    (res != RES_NQ),
        .pol     (idx_pol),
        .fire    (step.fire),
        .strobe  (strobe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_en     <= 1'b0;
            cnt_up     <= 1'b0;
            idx_strobe <= 1'b0;
            noise_err  <= 1'b0;
        end else begin
            cnt_en     <= step.fire;
            cnt_up     <= step.up;
            idx_strobe <= strobe;
            if (res == RES_NQ)  noise_err <= 1'b0;
            else if (noise_hit) noise_err <= 1'b1;
        end
    end
endmodule

// File: rtl/qdec_chk.sv
module qdec_chk (
    input logic       clk,
    input logic       rst,
    input logic       ab_en,
    input logic [1:0] res_mode,
    input logic       idx_sync,
    input logic       cnt_en,
    input logic       idx_strobe,
    input logic       noise_err
);
    AST_NQ_NOISE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (res_mode == 2'd0) |=> !noise_err); // R6

    AST_NOISE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (noise_err && res_mode != 2'd0) |=> noise_err); // R5

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !ab_en |=> !cnt_en); // R7

    AST_SYNC_IDX_WITH_COUNT: assert property (@(posedge clk) disable iff (rst)
        (idx_sync && res_mode != 2'd0) |=> (!idx_strobe || cnt_en)); // R9
endmodule

bind qdec_top qdec_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .ab_en     (ab_en),
    .res_mode  (res_mode),
    .idx_sync  (idx_sync),
    .cnt_en    (cnt_en),
    .idx_strobe(idx_strobe),
    .noise_err (noise_err)
);

// File: tb/qdec_top_tb_top.sv
`timescale 1ns/1ps
module qdec_top_tb_top;
    localparam int SETTLE = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_i = 1'b0, b_i = 1'b0, idx_i = 1'b1, en_i = 1'b1;
    logic [1:0] res_i = 2'd3;
    logic sync_i = 1'b0, pol_i = 1'b0;
    logic cnt_en, cnt_up, idx_strobe, noise_err;

    int n_checks = 0, n_errors = 0;
    int ups = 0, dns = 0, idxs = 0;

    always #4 clk = ~clk;

    qdec_top dut_i (
        .clk(clk), .rst(rst), .enc_a(a_i), .enc_b(b_i), .enc_idx(idx_i),
        .ab_en(en_i), .res_mode(res_i), .idx_sync(sync_i), .idx_pol(pol_i),
        .cnt_en(cnt_en), .cnt_up(cnt_up), .idx_strobe(idx_strobe),
        .noise_err(noise_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (cnt_en) begin
                if (cnt_up) ups++;
                else        dns++;
            end
            if (idx_strobe) idxs++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic a, input logic b);
        @(negedge clk);
        a_i = a;
        b_i = b;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic pulse_a(input int width);
        @(negedge clk);
        a_i = 1'b1;
        repeat (width) @(negedge clk);
        a_i = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    // one full encoder cycle starting from 00; up: 10,11,01,00 ; down: 01,11,10,00
    task automatic cycle(input bit up);
        if (up) begin
            drive(1, 0); drive(1, 1); drive(0, 1); drive(0, 0);
        end else begin
            drive(0, 1); drive(1, 1); drive(1, 0); drive(0, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int u0, d0, i0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 cnt_en", int'(cnt_en), 0);
        check("R11 noise_err", int'(noise_err), 0);
        check("R11 idx_strobe", int'(idx_strobe), 0);
        repeat (SETTLE) @(negedge clk);
        check("R11 idle strobes", idxs, 0);

        // R2/R3 sweeps over resolution and direction
        for (int m = 1; m <= 3; m++) begin
            for (int d = 0; d < 2; d++) begin
                int mult;
                mult = (m == 3) ? 4 : ((m == 2) ? 2 : 1);
                res_i = m[1:0];
                repeat (SETTLE) @(negedge clk);
                u0 = ups; d0 = dns;
                for (int k = 0; k < 3; k++) cycle(d == 0);
                check($sformatf("R2 mode%0d dir%0d same", m, d),
                      (d == 0) ? ups - u0 : dns - d0, 3 * mult);
                check($sformatf("R3 mode%0d dir%0d opposite", m, d),
                      (d == 0) ? dns - d0 : ups - u0, 0);
            end
        end

        // R4 filter window in x4
        res_i = 2'd3;
        u0 = ups; d0 = dns;
        pulse_a(2);
        check("R4 2-cycle glitch", (ups - u0) + (dns - d0), 0);
        u0 = ups; d0 = dns;
        pulse_a(3);
        check("R4 3-cycle pulse up", ups - u0, 1);
        check("R4 3-cycle pulse down", dns - d0, 1);

        // R7 input enable
        en_i = 1'b0;
        u0 = ups; d0 = dns;
        cycle(1);
        check("R7 disabled counts", (ups - u0) + (dns - d0), 0);
        en_i = 1'b1;
        u0 = ups;
        cycle(1);
        check("R7 re-enabled counts", ups - u0, 4);

        // R1 clock+direction mode
        res_i = 2'd0;
        b_i = 1'b1;
        repeat (SETTLE) @(negedge clk);
        u0 = ups; d0 = dns;
        pulse_a(1); pulse_a(1); pulse_a(4);
        check("R1 up pulses", ups - u0, 3);
        b_i = 1'b0;
        repeat (SETTLE) @(negedge clk);
        u0 = ups; d0 = dns;
        pulse_a(1); pulse_a(2);
        check("R1 down pulses", dns - d0, 2);
        check("R1 no up", ups - u0, 0);

        // R10 index forced to level mode when res_mode=0
        sync_i = 1'b1;
        i0 = idxs;
        @(negedge clk); idx_i = 1'b0;
        repeat (6) @(negedge clk); idx_i = 1'b1;
        repeat (SETTLE) @(negedge clk);
        check("R10 forced level strobes", idxs - i0, 6);

        // R8 level index in quadrature mode
        res_i = 2'd3; sync_i = 1'b0;
        repeat (SETTLE) @(negedge clk);
        i0 = idxs;
        @(negedge clk); idx_i = 1'b0;
        repeat (6) @(negedge clk); idx_i = 1'b1;
        repeat (SETTLE) @(negedge clk);
        check("R8 level strobes", idxs - i0, 6);

        // R9 qualified index
        sync_i = 1'b1; pol_i = 1'b1;
        idx_i = 1'b1;
        repeat (SETTLE) @(negedge clk);
        i0 = idxs;
        check("R9 idle no strobe", idxs - i0, 0);
        cycle(1);
        check("R9 active pol strobes", idxs - i0, 4);
        idx_i = 1'b0;
        repeat (SETTLE) @(negedge clk);
        i0 = idxs;
        cycle(1);
        check("R9 inactive pol strobes", idxs - i0, 0);
        pol_i = 1'b0;
        repeat (SETTLE) @(negedge clk);
        i0 = idxs;
        cycle(0);
        check("R9 low pol strobes", idxs - i0, 4);
        idx_i = 1'b1; sync_i = 1'b0;
        repeat (SETTLE) @(negedge clk);

        // R5 noise: both lines change together
        check("R5 noise clear before", int'(noise_err), 0);
        u0 = ups; d0 = dns;
        drive(1, 1);
        check("R5 noise set", int'(noise_err), 1);
        check("R5 no count on noise", (ups - u0) + (dns - d0), 0);
        drive(1, 0); drive(0, 0);
        check("R5 noise sticky", int'(noise_err), 1);

        // R6 cleared and held clear in mode 0
        res_i = 2'd0;
        repeat (3) @(negedge clk);
        check("R6 noise cleared", int'(noise_err), 0);
        drive(1, 1); drive(0, 0);
        check("R6 noise stays clear", int'(noise_err), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule